// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits between the interrupt request flags of an 8-bit microcontroller's peripherals and its core. Up to eighteen request slots are arranged into six priority groups. Slot `s` belongs to group `s mod 6`. A slot can be marked as having no source, and such a slot is never serviced. Software gives each group one of four priority levels by writing two 8-bit registers. Every slot in a group shares that group's level.

In each cycle the block finds the eligible request with the highest level. A request is eligible when it is pending, individually enabled and globally enabled. When several eligible requests share that level, the lowest slot index wins. The winner is forwarded to the core only if its level is strictly above every level already in service.

The core acknowledges a forwarded request, and the block then records the level as in service and latches the vector. A return-from-interrupt pulse retires the most recent, highest, in-service level. Four levels can nest in this way.

Top module: `grp_prio_intc`

## Requirements
- R1: After a synchronous reset, `int_req` is 0, `in_svc` is 0000, `svc_vec` is 0, and both priority registers are 0, so every group is at level 0.
- R2: A write to address A9h sets the low priority bits and a write to B9h sets the high priority bits. Bit g (g = 0..5) of each register belongs to group g. Writes to any other address change nothing.
- R3: A group's level is the 2-bit code {high bit, low bit}: 00 is level 0 (lowest), 01 is level 1, 10 is level 2 and 11 is level 3 (highest). `int_lvl` reports the level of the forwarded vector in this encoding.
- R4: Among the eligible requests, one at the highest level is selected.
- R5: When several eligible requests share the highest level, the lowest slot index is selected.
- R6: Slots marked unused (by default slots 15, 16 and 17) never produce `int_req`, even when pending and enabled.
- R7: A slot is eligible only when its `irq_pend` and `irq_en` bits are both 1 and `glob_en` is 1.
- R8: A request is forwarded only if its level is strictly greater than the highest level set in `in_svc`. If `in_svc` is empty, any level is forwarded.
- R9: `ack` while `int_req` is 1 sets the `in_svc` bit of `int_lvl` and copies `int_vec` into `svc_vec`. `int_req` is 0 in the following cycle.
- R10: A `reti` pulse clears the highest set bit of `in_svc`.
- R11: `int_req`, `int_vec` and `int_lvl` are registered. They reflect a request change one clock edge after the change. They reflect a priority write two edges after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| irq_pend | input | 18 | Pending request flags, one per slot |
| irq_en | input | 18 | Per-slot enables |
| glob_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Core accepts the forwarded request |
| reti | input | 1 | Core returns from the current handler |
| int_req | output | 1 | Request to the core |
| int_vec | output | 5 | Slot index of the forwarded request |
| int_lvl | output | 2 | Level of the forwarded request |
| svc_vec | output | 5 | Vector latched on the last acknowledge |
| in_svc | output | 4 | In-service level bits, bit n = level n |

## Verification
A corrupted priority register shows up as a wrong `int_vec` or `int_lvl` on the second edge after the write, once competing slots in different groups are pending. A damaged in-service stack shows up as a request that is forwarded too early or held back too long. That is visible on `int_req` in the cycle after an acknowledge or return pulse, and `in_svc` exposes the stack at the same time. A wrong polling order or a leak from an unused slot appears one edge after the pending pattern is applied.

// File: rtl/grp_prio_pkg.sv
package grp_prio_pkg;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/gp_prio_regs.sv
module gp_prio_regs
  import grp_prio_pkg::*;
#(
  parameter int              NGRP    = 6,
  parameter int              ADDR_W  = 8,
  parameter int              DATA_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'hA9,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'hB9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output lvl_t [NGRP-1:0]       grp_lvl
);
  logic [NGRP-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == LO_ADDR) lo_q <= wr_data[NGRP-1:0];
      if (wr_addr == HI_ADDR) hi_q <= wr_data[NGRP-1:0];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_lvl
    assign grp_lvl[g] = {hi_q[g], lo_q[g]};
  end

  // R1
  regs_cleared_chk: assert property (@(posedge clk) rst |=> (lo_q == '0 && hi_q == '0));
  // R2
  foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != LO_ADDR && wr_addr != HI_ADDR) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/gp_slot_arb.sv
module gp_slot_arb
  import grp_prio_pkg::*;
#(
  parameter int              NSRC      = 18,
  parameter int              NGRP      = 6,
  parameter int              VEC_W     = $clog2(NSRC),
  parameter logic [NSRC-1:0] SLOT_USED = 18'h07FFF
) (
  input  lvl_t [NGRP-1:0]   grp_lvl,
  input  logic [NSRC-1:0]   elig,
  output logic              win_valid,
  output logic [VEC_W-1:0]  win_vec,
  output lvl_t              win_lvl
);
  lvl_t [NSRC-1:0] slot_lvl;
  logic [NSRC-1:0] live;

  for (genvar s = 0; s < NSRC; s++) begin : g_slot
    assign slot_lvl[s] = grp_lvl[s % NGRP];
    assign live[s]     = elig[s] & SLOT_USED[s];
  end

  // Highest level first; within a level the descending scan leaves the
  // lowest index as the final assignment.
  always_comb begin
    win_valid = 1'b0;
    win_vec   = '0;
    win_lvl   = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (!win_valid) begin
        for (int s = NSRC - 1; s >= 0; s--) begin
          if (live[s] && slot_lvl[s] == lvl_t'(l)) begin
            win_valid = 1'b1;
            win_vec   = VEC_W'(s);
            win_lvl   = lvl_t'(l);
          end
        end
      end
    end
  end
endmodule

// File: rtl/gp_insvc.sv
module gp_insvc
  import grp_prio_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  lvl_t            set_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] in_svc,
  output logic            top_valid,
  output lvl_t            top_lvl
);
  logic [NLVL-1:0] nxt;

  always_comb begin
    top_valid = 1'b0;
    top_lvl   = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (in_svc[l]) begin
        top_valid = 1'b1;
        top_lvl   = lvl_t'(l);
      end
    end
  end

  always_comb begin
    nxt = in_svc;
    if (pop && top_valid) nxt[top_lvl] = 1'b0;
    if (set_en) nxt[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) in_svc <= '0;
    else     in_svc <= nxt;
  end

  // R9
  ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> in_svc[$past(set_lvl)]);
  // R10
  pop_one_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !set_en && in_svc != '0) |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));
  // R10
  pop_top_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !set_en && top_valid) |=> !in_svc[$past(top_lvl)]);
endmodule

// File: rtl/grp_prio_intc.sv
module grp_prio_intc
  import grp_prio_pkg::*;
#(
  parameter int              NGRP      = 6,
  parameter int              SLOTS     = 3,
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'hA9,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'hB9,
  parameter int              NSRC      = NGRP * SLOTS,
  parameter int              VEC_W     = $clog2(NSRC),
  parameter logic [NSRC-1:0] SLOT_USED = 18'h07FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   irq_pend,
  input  logic [NSRC-1:0]   irq_en,
  input  logic              glob_en,
  input  logic              ack,
  input  logic              reti,
  output logic              int_req,
  output logic [VEC_W-1:0]  int_vec,
  output logic [LVL_W-1:0]  int_lvl,
  output logic [VEC_W-1:0]  svc_vec,
  output logic [NLVL-1:0]   in_svc
);
  lvl_t [NGRP-1:0]  grp_lvl;
  logic [NSRC-1:0]  elig;
  logic             win_valid;
  logic [VEC_W-1:0] win_vec;
  lvl_t             win_lvl;
  logic             top_valid;
  lvl_t             top_lvl;
  logic             fwd;
  logic             take;

  gp_prio_regs #(
    .NGRP(NGRP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .grp_lvl(grp_lvl)
  );

  assign elig = irq_pend & irq_en & {NSRC{glob_en}};

  gp_slot_arb #(
    .NSRC(NSRC), .NGRP(NGRP), .VEC_W(VEC_W), .SLOT_USED(SLOT_USED)
  ) u_arb (
    .grp_lvl(grp_lvl), .elig(elig), .win_valid(win_valid),
    .win_vec(win_vec), .win_lvl(win_lvl)
  );

  assign take = ack & int_req;

  gp_insvc u_isv (
    .clk(clk), .rst(rst), .set_en(take), .set_lvl(int_lvl),
    .pop(reti), .in_svc(in_svc), .top_valid(top_valid), .top_lvl(top_lvl)
  );

  assign fwd = win_valid && (!top_valid || win_lvl > top_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req <= 1'b0;
      int_vec <= '0;
      int_lvl <= '0;
      svc_vec <= '0;
    end else begin
      int_req <= fwd & ~take;
      if (fwd) begin
        int_vec <= win_vec;
        int_lvl <= win_lvl;
      end
      if (take) svc_vec <= int_vec;
    end
  end

  // R6
  no_empty_slot_chk: assert property (@(posedge clk) disable iff (rst)
    int_req |-> SLOT_USED[int_vec]);
  // R7
  glob_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> !int_req);
  // R8
  above_svc_chk: assert property (@(posedge clk) disable iff (rst)
    int_req |-> ((in_svc >> int_lvl) == '0));
  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!int_req && svc_vec == $past(int_vec)));
endmodule

// File: tb/grp_prio_intc_tb_top.sv
module grp_prio_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [7:0]  reg_addr, reg_wdata;
  logic [17:0] irq_pend, irq_en;
  logic        glob_en, ack, reti;
  logic        int_req;
  logic [4:0]  int_vec, svc_vec;
  logic [1:0]  int_lvl;
  logic [3:0]  in_svc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  grp_prio_intc dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_pend(irq_pend), .irq_en(irq_en),
    .glob_en(glob_en), .ack(ack), .reti(reti), .int_req(int_req),
    .int_vec(int_vec), .int_lvl(int_lvl), .svc_vec(svc_vec), .in_svc(in_svc)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    irq_pend = 0; irq_en = '1; glob_en = 1; ack = 0; reti = 0;
    tick; tick; tick;
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick;
    reg_wr = 0;
    tick;
  endtask

  task automatic pulse_ack;
    ack = 1; tick; ack = 0;
  endtask

  task automatic pulse_reti;
    reti = 1; tick; reti = 0;
  endtask

  task automatic t_reset;
    do_reset;
    chk("R1 int_req", int_req, 0);
    chk("R1 in_svc", in_svc, 0);
    chk("R1 svc_vec", svc_vec, 0);
    irq_pend = 18'h00006;
    tick;
    chk("R1 all level0 vec", int_vec, 1);
    chk("R1 all level0 lvl", int_lvl, 0);
  endtask

  task automatic t_levels;
    do_reset;
    irq_pend = 18'h00005;
    wr(8'hA9, 8'h04);
    chk("R2 lo write vec", int_vec, 2);
    chk("R3 code 01 lvl", int_lvl, 1);
    wr(8'hB9, 8'h01);
    chk("R2 hi write vec", int_vec, 0);
    chk("R3 code 10 lvl", int_lvl, 2);
    wr(8'hA9, 8'h05);
    chk("R3 code 11 lvl", int_lvl, 3);
    wr(8'hAA, 8'hFF);
    wr(8'hB8, 8'hFF);
    irq_pend = 18'h00002;
    tick;
    chk("R2 foreign addr vec", int_vec, 1);
    chk("R2 foreign addr lvl", int_lvl, 0);
  endtask

  task automatic t_highest;
    do_reset;
    wr(8'hB9, 8'h10);
    irq_pend = (18'h1 << 1) | (18'h1 << 10) | (18'h1 << 4);
    tick;
    chk("R4 highest vec", int_vec, 4);
    chk("R4 highest lvl", int_lvl, 2);
  endtask

  task automatic t_tie;
    do_reset;
    irq_pend = (18'h1 << 13) | (18'h1 << 7);
    tick;
    chk("R5 tie vec", int_vec, 7);
    irq_pend = 18'h1 << 13;
    tick;
    chk("R5 single vec", int_vec, 13);
  endtask

  task automatic t_unused;
    do_reset;
    wr(8'hA9, 8'h38);
    wr(8'hB9, 8'h38);
    irq_pend = 18'h38000;
    tick;
    chk("R6 unused req", int_req, 0);
    irq_pend = 18'h38008;
    tick;
    chk("R6 used req", int_req, 1);
    chk("R6 used vec", int_vec, 3);
  endtask

  task automatic t_gating;
    do_reset;
    irq_pend = 18'h1 << 5;
    irq_en = 18'h0;
    tick;
    chk("R7 en off", int_req, 0);
    irq_en = '1; glob_en = 0;
    tick;
    chk("R7 glob off", int_req, 0);
    glob_en = 1;
    tick;
    chk("R7 both on req", int_req, 1);
    chk("R7 both on vec", int_vec, 5);
    irq_en = 18'h1 << 5; irq_pend = 18'h0;
    tick;
    chk("R7 pend off", int_req, 0);
  endtask

  task automatic t_nest;
    do_reset;
    wr(8'hA9, 8'h05);
    wr(8'hB9, 8'h06);
    irq_pend = 18'h1;
    tick;
    chk("R11 req after pend", int_req, 1);
    chk("R3 lvl1", int_lvl, 1);
    pulse_ack;
    chk("R9 req drop", int_req, 0);
    chk("R9 svc_vec", svc_vec, 0);
    chk("R9 in_svc", in_svc, 4'b0010);
    tick;
    chk("R8 equal held", int_req, 0);
    irq_pend = 18'h3;
    tick;
    chk("R8 higher vec", int_vec, 1);
    chk("R8 higher req", int_req, 1);
    pulse_ack;
    chk("R9 nest2", in_svc, 4'b0110);
    chk("R9 svc_vec2", svc_vec, 1);
    irq_pend = 18'h7;
    tick;
    chk("R8 lvl3 vec", int_vec, 2);
    pulse_ack;
    chk("R9 nest3", in_svc, 4'b1110);
    tick;
    chk("R8 top held", int_req, 0);
    pulse_reti;
    chk("R10 pop top", in_svc, 4'b0110);
    tick;
    chk("R10 reissue req", int_req, 1);
    chk("R10 reissue vec", int_vec, 2);
    irq_pend = 18'h0;
    pulse_reti;
    chk("R10 pop2", in_svc, 4'b0010);
    pulse_reti;
    chk("R10 pop3", in_svc, 4'b0000);
  endtask

  task automatic t_level0_block;
    do_reset;
    irq_pend = 18'h1 << 9;
    tick;
    pulse_ack;
    chk("R9 level0 in_svc", in_svc, 4'b0001);
    tick;
    chk("R8 level0 held", int_req, 0);
    pulse_reti;
    tick;
    chk("R10 level0 reissue", int_req, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_levels;
    t_highest;
    t_tie;
    t_unused;
    t_gating;
    t_nest;
    t_level0_block;
    finish_run;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule